// File: doc/BRIEF.md
# SPI Target Controller with Packed Word FIFOs

This block is the target (peripheral) side of an SPI link. A host processor sees it through a small 32-bit register window. An external controller drives the serial clock and chip select. While chip select is low, the block shifts one byte at a time in either direction. It supports all four clock-polarity and clock-phase combinations. The transmit and receive bit orders are chosen independently.

Outgoing data is staged in a byte FIFO. The host fills it one 32-bit word at a time, and each word supplies four bytes, lowest byte first. Incoming bytes go into a second byte FIFO. The host drains it as 32-bit words, and a partially filled last word reads back with zeros in its missing upper bytes. Three transfer events raise sticky status flags: a clean end, an end in the middle of a byte, and a start with both directions switched off. Each flag has an enable and a pass mask, and the flags drive one interrupt line. A soft-reset command clears both FIFOs and the shift state and leaves every setting in place.

The serial inputs are synchronised into the system clock domain, so the serial clock must run at no more than a quarter of the system clock.

Top module: `spit_core`

## Requirements
- R1: After reset, the configuration, interrupt-enable, interrupt-mask and status registers read as zero, `irq` is low, and a read of the receive data register (0x14) returns 0.
- R2: The configuration register at 0x10 stores bits 7:0 and reads them back. Bits 7 and 6 (byte-swap selects) are kept but have no effect on the data.
- R3: Each write to 0x18 queues four bytes, least significant byte first, and they leave on MISO in that order. When transmit is enabled (config bit 1) and the queue is empty, 0x00 is sent.
- R4: Received bytes are packed least significant byte first. A read of 0x14 removes up to four bytes, and absent upper bytes read as zero. With receive disabled (config bit 0 clear), incoming bytes are dropped.
- R5: Config bit 4 set makes reception MSB-first and config bit 5 set makes transmission MSB-first. When a bit is clear, that direction is LSB-first.
- R6: Config bit 2 sets the idle clock level (CPOL) and bit 3 sets the phase (CPHA). With phase 0, data is captured on the leading edge; with phase 1, it is captured on the trailing edge. All four combinations work.
- R7: Status bit 2 (done) is set when chip select rises after one or more whole bytes with no partial byte pending.
- R8: Status bit 1 (abort) is set, and done is not set, when chip select rises in the middle of a byte.
- R9: Status bit 0 (invalid) is set when chip select falls while config bits 0 and 1 are both clear.
- R10: Writing to 0x4 clears exactly the status bits written as 1. Status reads at 0x8.
- R11: `irq` is the OR over the bits set in all three of status, enable (0x0) and mask (0xC). A mask bit of 1 lets its source through.
- R12: Writing bit 0 = 1 to 0x40 empties both FIFOs and idles the shifter. Configuration, enable and mask values are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (a read of 0x14 pops data) |
| reg_addr | input | AW | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the same cycle as the strobe |
| irq | output | 1 | Interrupt request |
| spi_sck | input | 1 | Serial clock from the controller |
| spi_csn | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block, driven low when not selected |

## Verification
A wrong bit counter or wrong edge selection shows up on the first byte of a transfer. MISO then carries a shifted or bit-reversed value, and the packed receive word is wrong by the time the host reads it. A transmit pop at the wrong moment makes later bytes repeat or skip, so MISO diverges within one byte period. A stuck or mis-cleared status bit shows on `irq` and on the status register a few system cycles after chip select rises, once the synchroniser has passed the edge through. Leftover FIFO contents after soft reset show up immediately as non-zero receive reads or non-zero MISO bytes.

// File: rtl/spit_pkg.sv
package spit_pkg;
   // register byte offsets
   localparam int OFF_IRQ_EN  = 'h00;
   localparam int OFF_IRQ_CLR = 'h04;
   localparam int OFF_IRQ_ST  = 'h08;
   localparam int OFF_IRQ_MSK = 'h0C;
   localparam int OFF_CFG     = 'h10;
   localparam int OFF_RXDATA  = 'h14;
   localparam int OFF_TXDATA  = 'h18;
   localparam int OFF_SRST    = 'h40;

   // event bit positions, shared by enable, status, clear and mask
   localparam int EV_INVALID = 0;
   localparam int EV_ABORT   = 1;
   localparam int EV_DONE    = 2;
   localparam int EV_W       = 3;

   typedef struct packed {
      logic tx_swap;   // stored only
      logic rx_swap;   // stored only
      logic tx_msb;
      logic rx_msb;
      logic cpha;
      logic cpol;
      logic tx_en;
      logic rx_en;
   } cfg_t;
endpackage

// File: rtl/spit_byte_fifo.sv
module spit_byte_fifo #(
   parameter int DEPTH      = 512,
   parameter int PUSH_LANES = 4,
   parameter int POP_LANES  = 1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              flush,
   input  logic [$clog2(PUSH_LANES+1)-1:0]   push_n,
   input  logic [PUSH_LANES*8-1:0]           push_data,
   input  logic [$clog2(POP_LANES+1)-1:0]    pop_n,
   output logic [POP_LANES*8-1:0]            peek,
   output logic [$clog2(DEPTH+1)-1:0]        count
);
   localparam int PW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH+1);
   localparam int MAXL = (PUSH_LANES > POP_LANES) ? PUSH_LANES : POP_LANES;

   if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("spit_byte_fifo: DEPTH must be a power of two");
   end
   if (DEPTH < 2 * MAXL) begin : g_small_depth
      $error("spit_byte_fifo: DEPTH too small for lane count");
   end

   logic [7:0]    mem [DEPTH];
   logic [PW-1:0] wp, rp;
   logic [CW-1:0] after_pop;
   logic          fits;
   logic [$clog2(PUSH_LANES+1)-1:0] push_ok;

   assign after_pop = count - CW'(pop_n);
   assign fits      = ({1'b0, after_pop} + (CW+1)'(push_n)) <= (CW+1)'(DEPTH);
   assign push_ok   = fits ? push_n : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else if (flush) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         wp    <= wp + PW'(push_ok);
         rp    <= rp + PW'(pop_n);
         count <= after_pop + CW'(push_ok);
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < PUSH_LANES; i++) begin
         if (!flush && (i < int'(push_ok)))
            mem[wp + PW'(i)] <= push_data[i*8 +: 8];
      end
   end

   for (genvar g = 0; g < POP_LANES; g++) begin : g_peek
      assign peek[g*8 +: 8] = (CW'(g) < count) ? mem[rp + PW'(g)] : 8'h00;
   end

   // R4
   pop_le_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      CW'(pop_n) <= count);
   // R12
   count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
endmodule

// File: rtl/spit_shift_engine.sv
module spit_shift_engine #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       soft_rst,
   input  logic       sck_in,
   input  logic       csn_in,
   input  logic       mosi_in,
   input  logic       cpol,
   input  logic       cpha,
   input  logic       tx_msb,
   input  logic       rx_msb,
   input  logic       tx_en,
   input  logic       rx_en,
   input  logic       tx_avail,
   input  logic [7:0] tx_byte,
   output logic       miso,
   output logic       tx_pop,
   output logic       rx_push,
   output logic [7:0] rx_byte,
   output logic       ev_done,
   output logic       ev_abort,
   output logic       ev_invalid
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("spit_shift_engine: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sck_p, csn_p, mosi_p;
   logic sck_s, csn_s, mosi_s, sck_q, csn_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_p  <= '0;
         csn_p  <= '1;
         mosi_p <= '0;
         sck_q  <= 1'b0;
         csn_q  <= 1'b1;
      end else begin
         sck_p  <= {sck_p[SYNC_STAGES-2:0], sck_in};
         csn_p  <= {csn_p[SYNC_STAGES-2:0], csn_in};
         mosi_p <= {mosi_p[SYNC_STAGES-2:0], mosi_in};
         sck_q  <= sck_s;
         csn_q  <= csn_s;
      end
   end

   assign sck_s  = sck_p[SYNC_STAGES-1];
   assign csn_s  = csn_p[SYNC_STAGES-1];
   assign mosi_s = mosi_p[SYNC_STAGES-1];

   logic cs_act, cs_fall, cs_rise, lead, trail, smp, shf;
   assign cs_act  = !csn_s;
   assign cs_fall = csn_q && !csn_s;
   assign cs_rise = !csn_q && csn_s;
   assign lead    = ((sck_s ^ cpol) && !(sck_q ^ cpol));
   assign trail   = (!(sck_s ^ cpol) && (sck_q ^ cpol));
   assign smp     = cs_act && !cs_fall && (cpha ? trail : lead);
   assign shf     = cs_act && !cs_fall && (cpha ? lead : trail);

   logic [2:0] bit_cnt;
   logic [7:0] rx_sh, tx_sh;
   logic       from_fifo, got_byte, take;

   assign take    = tx_en && tx_avail;
   assign rx_byte = rx_msb ? {rx_sh[6:0], mosi_s} : {mosi_s, rx_sh[7:1]};
   assign rx_push = smp && (bit_cnt == 3'd7) && rx_en && !soft_rst;
   assign tx_pop  = smp && (bit_cnt == 3'd0) && from_fifo && !soft_rst;
   assign miso    = cs_act ? (tx_msb ? tx_sh[7] : tx_sh[0]) : 1'b0;

   assign ev_done    = cs_rise && (bit_cnt == 3'd0) && got_byte && !soft_rst;
   assign ev_abort   = cs_rise && (bit_cnt != 3'd0) && !soft_rst;
   assign ev_invalid = cs_fall && !tx_en && !rx_en && !soft_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt   <= '0;
         rx_sh     <= '0;
         tx_sh     <= '0;
         from_fifo <= 1'b0;
         got_byte  <= 1'b0;
      end else if (soft_rst || cs_rise) begin
         bit_cnt   <= '0;
         tx_sh     <= '0;
         from_fifo <= 1'b0;
         got_byte  <= 1'b0;
      end else if (cs_fall || (shf && bit_cnt == 3'd0)) begin
         // present the head byte; it is popped on its first capture edge
         tx_sh     <= take ? tx_byte : 8'h00;
         from_fifo <= take;
      end else if (smp) begin
         rx_sh   <= rx_byte;
         bit_cnt <= bit_cnt + 3'd1;
         if (bit_cnt == 3'd0) from_fifo <= 1'b0;
         if (bit_cnt == 3'd7) got_byte  <= 1'b1;
      end else if (shf) begin
         tx_sh <= tx_msb ? {tx_sh[6:0], 1'b0} : {1'b0, tx_sh[7:1]};
      end
   end

   // R8
   idle_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (csn_s && csn_q) |-> (bit_cnt == 3'd0));
endmodule

// File: rtl/spit_core.sv
module spit_core #(
   parameter int FIFO_BYTES  = 512,
   parameter int AW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic          reg_re,
   input  logic [AW-1:0] reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   output logic          irq,
   input  logic          spi_sck,
   input  logic          spi_csn,
   input  logic          spi_mosi,
   output logic          spi_miso
);
   import spit_pkg::*;

   localparam int LANES = 4;
   localparam int CW    = $clog2(FIFO_BYTES+1);
   localparam int NW    = $clog2(LANES+1);

   if (AW < 7) begin : g_bad_aw
      $error("spit_core: AW must reach offset 0x40");
   end

   cfg_t            cfg;
   logic [EV_W-1:0] irq_en, irq_st, irq_msk, ev, clr;
   logic            soft_rst, clr_hit, tx_pop, rx_push, tx_wr;
   logic [7:0]      rx_byte;
   logic [31:0]     rx_peek;
   logic [7:0]      tx_peek;
   logic [CW-1:0]   rx_cnt, tx_cnt;
   logic [NW-1:0]   rx_pop_n;

   assign soft_rst = reg_we && (reg_addr == AW'(OFF_SRST)) && reg_wdata[0];
   assign clr_hit  = reg_we && (reg_addr == AW'(OFF_IRQ_CLR));
   assign clr      = clr_hit ? reg_wdata[EV_W-1:0] : '0;
   assign tx_wr    = reg_we && (reg_addr == AW'(OFF_TXDATA));
   assign rx_pop_n = !(reg_re && reg_addr == AW'(OFF_RXDATA)) ? '0 :
                     (rx_cnt >= CW'(LANES)) ? NW'(LANES) : NW'(rx_cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg     <= '0;
         irq_en  <= '0;
         irq_msk <= '0;
         irq_st  <= '0;
      end else begin
         if (reg_we && reg_addr == AW'(OFF_CFG))     cfg     <= cfg_t'(reg_wdata[7:0]);
         if (reg_we && reg_addr == AW'(OFF_IRQ_EN))  irq_en  <= reg_wdata[EV_W-1:0];
         if (reg_we && reg_addr == AW'(OFF_IRQ_MSK)) irq_msk <= reg_wdata[EV_W-1:0];
         irq_st <= (irq_st & ~clr) | ev;
      end
   end

   assign irq = |(irq_st & irq_en & irq_msk);

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         AW'(OFF_IRQ_EN):  reg_rdata[EV_W-1:0] = irq_en;
         AW'(OFF_IRQ_ST):  reg_rdata[EV_W-1:0] = irq_st;
         AW'(OFF_IRQ_MSK): reg_rdata[EV_W-1:0] = irq_msk;
         AW'(OFF_CFG):     reg_rdata[7:0]      = cfg;
         AW'(OFF_RXDATA):  reg_rdata           = rx_peek;
         default:          reg_rdata           = '0;
      endcase
   end

   spit_byte_fifo #(.DEPTH(FIFO_BYTES), .PUSH_LANES(LANES), .POP_LANES(1)) u_txq (
      .clk(clk), .rst_n(rst_n), .flush(soft_rst),
      .push_n(tx_wr ? NW'(LANES) : NW'(0)), .push_data(reg_wdata),
      .pop_n(tx_pop), .peek(tx_peek), .count(tx_cnt));

   spit_byte_fifo #(.DEPTH(FIFO_BYTES), .PUSH_LANES(1), .POP_LANES(LANES)) u_rxq (
      .clk(clk), .rst_n(rst_n), .flush(soft_rst),
      .push_n(rx_push), .push_data(rx_byte),
      .pop_n(rx_pop_n), .peek(rx_peek), .count(rx_cnt));

   spit_shift_engine #(.SYNC_STAGES(SYNC_STAGES)) u_eng (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .sck_in(spi_sck), .csn_in(spi_csn), .mosi_in(spi_mosi),
      .cpol(cfg.cpol), .cpha(cfg.cpha), .tx_msb(cfg.tx_msb), .rx_msb(cfg.rx_msb),
      .tx_en(cfg.tx_en), .rx_en(cfg.rx_en),
      .tx_avail(tx_cnt != '0), .tx_byte(tx_peek),
      .miso(spi_miso), .tx_pop(tx_pop), .rx_push(rx_push), .rx_byte(rx_byte),
      .ev_done(ev[EV_DONE]), .ev_abort(ev[EV_ABORT]), .ev_invalid(ev[EV_INVALID]));

   // R10
   w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit && reg_wdata[EV_ABORT] && !ev[EV_ABORT]) |=> !irq_st[EV_ABORT]);
   // R12
   srst_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (rx_cnt == '0 && tx_cnt == '0));
   // R11
   irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (irq_st != '0));
endmodule

// File: tb/spit_core_tb.sv
module spit_core_tb;
   localparam int HALF = 8;
   localparam logic [7:0] A_EN = 8'h00, A_CLR = 8'h04, A_ST = 8'h08, A_MSK = 8'h0C,
                          A_CFG = 8'h10, A_RX = 8'h14, A_TX = 8'h18, A_SRST = 8'h40;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n, reg_we, reg_re, irq, sck, csn, mosi, miso;
   logic [7:0] reg_addr;
   logic [31:0] reg_wdata, reg_rdata, rv;

   spit_core u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
      .spi_sck(sck), .spi_csn(csn), .spi_mosi(mosi), .spi_miso(miso));

   int checks = 0, errors = 0;
   logic m_cpol = 1'b0, m_cpha = 1'b0;
   logic [7:0] exp_q [$];
   string      tag_q [$];
   logic [7:0] got_b;
   event       byte_ev;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] rev8(input logic [7:0] b);
      for (int i = 0; i < 8; i++) rev8[i] = b[7-i];
   endfunction

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk); reg_re = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk); reg_re = 1'b0;
   endtask

   task automatic cs_begin();
      @(negedge clk); sck = m_cpol;
      repeat (4) @(negedge clk);
      csn = 1'b0;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic cs_end();
      repeat (HALF) @(negedge clk);
      csn = 1'b1;
      repeat (8) @(negedge clk);
   endtask

   task automatic shift_bits(input logic [7:0] w, input int n, output logic [7:0] r);
      r = '0;
      for (int k = 0; k < n; k++) begin
         if (!m_cpha) begin
            mosi = w[7-k];
            repeat (HALF) @(negedge clk);
            r[7-k] = miso; sck = ~m_cpol;
            repeat (HALF) @(negedge clk);
            sck = m_cpol;
         end else begin
            sck = ~m_cpol; mosi = w[7-k];
            repeat (HALF) @(negedge clk);
            r[7-k] = miso; sck = m_cpol;
            repeat (HALF) @(negedge clk);
         end
      end
   endtask

   // driver: queue the expected MISO byte, then clock the byte
   task automatic send(input logic [7:0] w, input logic [7:0] e, input string t);
      logic [7:0] r;
      exp_q.push_back(e); tag_q.push_back(t);
      shift_bits(w, 8, r);
      got_b = r; ->byte_ev;
   endtask

   // monitor: compare each completed MISO byte against the scoreboard
   initial begin
      forever begin
         @(byte_ev);
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R3: unexpected byte actual 0x%02h expected none", got_b);
         end else begin
            chk(tag_q.pop_front(), {24'b0, got_b}, {24'b0, exp_q.pop_front()});
         end
      end
   end

   logic done_flag = 1'b0;
   initial begin
      repeat (200000) @(posedge clk);
      if (!done_flag) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] dummy;
      rst_n = 1'b0; reg_we = 1'b0; reg_re = 1'b0; reg_addr = '0; reg_wdata = '0;
      sck = 1'b0; csn = 1'b1; mosi = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(A_ST, rv);  chk("R1 status", rv, 0);
      rd(A_CFG, rv); chk("R1 config", rv, 0);
      rd(A_EN, rv);  chk("R1 enable", rv, 0);
      rd(A_MSK, rv); chk("R1 mask", rv, 0);
      rd(A_RX, rv);  chk("R1 empty rx", rv, 0);
      chk("R1 irq", {31'b0, irq}, 0);

      // mode 0, MSB first both ways, swap bits set (R2, R3, R6, R7, R11)
      wr(A_CFG, 32'hF3); rd(A_CFG, rv); chk("R2 config readback", rv, 32'hF3);
      wr(A_EN, 7); wr(A_MSK, 7);
      wr(A_TX, 32'h44332211);
      m_cpol = 0; m_cpha = 0;
      cs_begin(); send(8'hA5, 8'h11, "R3 mode0 byte0"); send(8'h3C, 8'h22, "R3 mode0 byte1"); cs_end();
      rd(A_RX, rv); chk("R4 partial word", rv, 32'h00003CA5);
      rd(A_ST, rv); chk("R7 done", rv, 4);
      chk("R11 irq on", {31'b0, irq}, 1);
      wr(A_CLR, 4); rd(A_ST, rv); chk("R10 clear done", rv, 0);

      // mode 3, TX LSB first, RX MSB first (R5, R6)
      wr(A_SRST, 1); wr(A_CFG, 32'h1F); m_cpol = 1; m_cpha = 1;
      wr(A_TX, 32'h000080C1);
      cs_begin(); send(8'h12, rev8(8'hC1), "R5 tx lsb mode3"); send(8'h34, rev8(8'h80), "R5 tx lsb mode3 b1"); cs_end();
      rd(A_RX, rv); chk("R6 mode3 rx", rv, 32'h00003412);

      // mode 1, TX MSB first, RX LSB first (R5, R6)
      wr(A_SRST, 1); wr(A_CFG, 32'h2B); m_cpol = 0; m_cpha = 1;
      wr(A_TX, 32'hDDCCBBAA);
      cs_begin();
      send(8'h01, 8'hAA, "R6 mode1 b0"); send(8'h80, 8'hBB, "R6 mode1 b1"); send(8'hF0, 8'hCC, "R6 mode1 b2");
      cs_end();
      rd(A_RX, rv); chk("R5 rx lsb", rv, {8'h00, rev8(8'hF0), rev8(8'h80), rev8(8'h01)});

      // mode 2, empty TX queue sends zero (R3, R4)
      wr(A_SRST, 1); wr(A_CFG, 32'h37); m_cpol = 1; m_cpha = 0;
      cs_begin();
      for (int i = 1; i <= 5; i++) send(8'(i * 8'h11), 8'h00, "R3 empty tx zero");
      cs_end();
      rd(A_RX, rv); chk("R4 full word", rv, 32'h44332211);
      rd(A_RX, rv); chk("R4 tail word", rv, 32'h00000055);
      rd(A_RX, rv); chk("R4 drained", rv, 0);

      // abort mid-byte (R8) and exact clear (R10)
      wr(A_CLR, 7); wr(A_CFG, 32'h33); m_cpol = 0; m_cpha = 0;
      cs_begin(); shift_bits(8'hFF, 3, dummy); cs_end();
      rd(A_ST, rv); chk("R8 abort only", rv, 2);
      cs_begin(); send(8'h10, 8'h00, "R3 empty after abort"); cs_end();
      rd(A_ST, rv); chk("R7 done plus abort", rv, 6);
      rd(A_RX, rv);
      wr(A_CLR, 2); rd(A_ST, rv); chk("R10 exact clear", rv, 4);

      // masking (R11)
      wr(A_MSK, 0); chk("R11 masked", {31'b0, irq}, 0);
      wr(A_MSK, 4); chk("R11 mask passes", {31'b0, irq}, 1);
      wr(A_EN, 3); wr(A_MSK, 7); chk("R11 not enabled", {31'b0, irq}, 0);
      wr(A_EN, 7);

      // receive disabled (R4)
      wr(A_CFG, 32'h32);
      cs_begin(); send(8'h99, 8'h00, "R3 rx off tx"); cs_end();
      rd(A_RX, rv); chk("R4 rx disabled drops", rv, 0);

      // invalid start (R9)
      wr(A_CLR, 7); wr(A_CFG, 32'h30);
      cs_begin(); cs_end();
      rd(A_ST, rv); chk("R9 invalid", rv, 1);
      chk("R9 irq", {31'b0, irq}, 1);

      // soft reset (R12)
      wr(A_CLR, 7); wr(A_CFG, 32'h33);
      wr(A_TX, 32'hEEEEEEEE);
      cs_begin(); send(8'h5A, 8'hEE, "R3 before srst"); cs_end();
      wr(A_SRST, 1);
      rd(A_CFG, rv); chk("R12 config kept", rv, 32'h33);
      rd(A_EN, rv);  chk("R12 enable kept", rv, 7);
      rd(A_RX, rv);  chk("R12 rx flushed", rv, 0);
      cs_begin(); send(8'h77, 8'h00, "R12 tx flushed"); cs_end();
      rd(A_RX, rv);  chk("R12 rx after srst", rv, 32'h00000077);

      done_flag = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule